// File: doc/BRIEF.md
# Serial EEPROM Bit-Level Slave

This block models a small serial EEPROM that answers an I2C master which toggles the clock and data lines by software. The host writes new SCL and SDA levels one update at a time, pulsing a write strobe each time. The slave compares every update with the levels stored at the previous update. From that comparison it finds start and stop conditions and clock rising edges. It then returns the data-line level that the host reads back.

A transaction opens with a start condition. The slave shifts in an 8-bit command byte and pulls SDA low to acknowledge it. It then shifts in an 8-bit word address. During those same eight clocks it shifts out its data register when bit 0 of the command requests a read. After the last address bit it loads the data register from the addressed byte of a 256-entry image and acknowledges once more. The image is a register array that takes fixed contents at reset. Because the read data is shifted out during the address phase, a read returns the byte that the previous transaction latched. This is why a write-command transaction is used to point at a location before reading it.

Top module: `serial_eeprom_slave`

## Requirements
- R1: While and after reset, with no strobe yet, `sda_o` is 1 (line released) and the slave is idle.
- R2: A strobe with SCL high at both the previous and the current update, where SDA falls from 1 to 0, is a start. It restarts the command byte from bit count zero, even in the middle of a transaction. An SDA rise with SCL high is a stop and changes no transaction state.
- R3: While the slave is idle (no transaction bit in progress and no acknowledge pending), clock edges and data bits have no effect. The slave neither shifts nor acknowledges until a start condition arrives.
- R4: A bit is taken only on an SCL rising edge (SCL 0 at the previous update, 1 at this one). The SDA level must also equal the level stored at the previous update. A rising edge with a different SDA is ignored.
- R5: Command bits enter MSB first. After the 8th command bit, the next SCL rising edge drives `sda_o` to 0 (acknowledge) and clears the pending acknowledge.
- R6: With command bit 0 equal to 1 (read), each of the 8 address-phase rising edges sets `sda_o` to the master's SDA AND the data register MSB. The data register then shifts left.
- R7: With command bit 0 equal to 0 (write), `sda_o` follows the master's SDA through the address phase.
- R8: After the 8th address bit (MSB first), the data register loads the image byte at that address. An acknowledge becomes pending and the slave then goes idle.
- R9: The image byte at address a is (a*IMG_MUL + IMG_ADD) mod 256, with defaults IMG_MUL=5 and IMG_ADD=0x3C.
- R10: Without a strobe, no state of the slave changes and `sda_o` holds its value.
- R11: The slave never returns a 1 on `sda_o` after an update in which the master drove SDA to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle pulse: the host has written new line levels |
| scl_i | input | 1 | Clock level written by the master |
| sda_i | input | 1 | Data level written by the master (1 = released) |
| sda_o | output | 1 | Data line as seen by the host after this slave's open-drain pull |

## Verification
The address phase is run three ways. A write command with a mixed address pattern shows that the line follows the master. A read command with an all-ones address shows the latched byte bit for bit. A read command with a partly-zero address shows the wired-AND of master and slave. Three bit sequences are each judged by where the acknowledge lands: a bit with SDA changed at the rising edge, a stop in the middle of a byte, and a repeated start after three bits. Together they separate correct bit counting from a counter that is off by one. A clocked byte with no start checks that an idle slave stays silent.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;
  localparam int CMD_W   = 8;
  localparam int RD_FLAG = 0;

  // reset-time image value for one location
  function automatic logic [31:0] img_word(int unsigned addr, int unsigned mul,
                                           int unsigned add);
    return 32'(addr * mul + add);
  endfunction
endpackage

// File: rtl/seeprom_image.sv
module seeprom_image #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int unsigned IMG_MUL = 5,
  parameter int unsigned IMG_ADD = 8'h3C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= DW'(serial_eeprom_pkg::img_word(g, IMG_MUL, IMG_ADD));
      else         mem_q[g] <= mem_q[g];
    end
  end

  assign data_o = mem_q[addr_i];
endmodule

// File: rtl/seeprom_seq.sv
module seeprom_seq #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int CMD_W = serial_eeprom_pkg::CMD_W,
  localparam int CMD_END  = CMD_W + 1,
  localparam int XFER_END = CMD_END + AW,
  localparam int TW       = $clog2(XFER_END + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             line_o,
  output logic             scl_q_o,
  output logic [TW-1:0]    tick_o,
  output logic             ack_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic             scl_q, line_q, ack_q, ack_n, line_n;
  logic [TW-1:0]    tick_q, tick_n, tick_inc;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic [AW-1:0]    addr_q, addr_n, addr_shift;
  logic [DW-1:0]    data_q, data_n;
  logic             cond_w, rise_w, idle_w;

  assign cond_w     = scl_q & scl_i & (line_q != sda_i);
  assign rise_w     = ~scl_q & scl_i;
  assign idle_w     = (tick_q == '0) & ~ack_q;
  assign tick_inc   = tick_q + 1'b1;
  assign addr_shift = {addr_q[AW-2:0], sda_i};
  assign rd_addr_o  = addr_shift;

  always_comb begin
    tick_n = tick_q;
    ack_n  = ack_q;
    cmd_n  = cmd_q;
    addr_n = addr_q;
    data_n = data_q;
    line_n = sda_i;
    if (cond_w) begin
      if (!sda_i) begin  // start; a stop leaves everything alone
        tick_n = TW'(1);
        cmd_n  = '0;
      end
    end else if (!idle_w && rise_w) begin
      if (ack_q) begin
        line_n = 1'b0;
        ack_n  = 1'b0;
      end else if (sda_i == line_q) begin
        if (tick_q < TW'(CMD_END)) begin
          cmd_n  = {cmd_q[CMD_W-2:0], sda_i};
          tick_n = tick_inc;
          if (tick_inc == TW'(CMD_END)) ack_n = 1'b1;
        end else if (tick_q < TW'(XFER_END)) begin
          if (cmd_q[serial_eeprom_pkg::RD_FLAG]) line_n = sda_i & data_q[DW-1];
          addr_n = addr_shift;
          data_n = {data_q[DW-2:0], 1'b0};
          tick_n = tick_inc;
          if (tick_inc == TW'(XFER_END)) begin
            data_n = rd_data_i;
            ack_n  = 1'b1;
            tick_n = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      line_q <= 1'b1;
      tick_q <= '0;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (stb_i) begin
      scl_q  <= scl_i;
      line_q <= line_n;
      tick_q <= tick_n;
      ack_q  <= ack_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign line_o  = line_q;
  assign scl_q_o = scl_q;
  assign tick_o  = tick_q;
  assign ack_o   = ack_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int unsigned IMG_MUL = 5,
  parameter int unsigned IMG_ADD = 8'h3C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stb_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  localparam int CMD_W = serial_eeprom_pkg::CMD_W;
  localparam int TW    = $clog2(CMD_W + AW + 2);

  logic [AW-1:0]    rd_addr_w;
  logic [DW-1:0]    rd_data_w;
  logic             line_w, scl_q_w, ack_w;
  logic [TW-1:0]    tick_w;
  logic [CMD_W-1:0] cmd_w;

  seeprom_seq #(.AW(AW), .DW(DW), .CMD_W(CMD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (wr_stb_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .rd_data_i(rd_data_w),
    .rd_addr_o(rd_addr_w),
    .line_o   (line_w),
    .scl_q_o  (scl_q_w),
    .tick_o   (tick_w),
    .ack_o    (ack_w),
    .cmd_o    (cmd_w)
  );

  seeprom_image #(.AW(AW), .DW(DW), .IMG_MUL(IMG_MUL), .IMG_ADD(IMG_ADD)) u_img (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(rd_addr_w),
    .data_o(rd_data_w)
  );

  assign sda_o = line_w;
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int AW    = 8,
  parameter int CMD_W = 8,
  localparam int XFER_END = CMD_W + AW + 1,
  localparam int TW       = $clog2(XFER_END + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stb,
  input logic             scl,
  input logic             sda,
  input logic             sda_o,
  input logic             scl_q,
  input logic [TW-1:0]    tick,
  input logic             ack,
  input logic [CMD_W-1:0] cmd
);
  logic start_w, rise_w;
  assign start_w = stb & scl_q & scl & sda_o & ~sda;
  assign rise_w  = stb & ~scl_q & scl;

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (tick == TW'(1)) && (cmd == '0));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && tick == '0 && !ack && !start_w) |=> (tick == '0) && !ack);

  assert_bad_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w && !ack && sda != sda_o) |=> $stable(tick));

  assert_ack_serve_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w && ack) |=> !sda_o && !ack);

  assert_load_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w && !ack && sda == sda_o && tick == TW'(XFER_END - 1)) |=> ack && (tick == '0));

  assert_tick_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick < TW'(XFER_END));

  assert_no_stb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb |=> $stable(sda_o) && $stable(tick) && $stable(ack) && $stable(cmd));

  assert_open_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !sda) |=> !sda_o);
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.AW(AW), .CMD_W(CMD_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .stb   (wr_stb_i),
  .scl   (scl_i),
  .sda   (sda_i),
  .sda_o (sda_o),
  .scl_q (scl_q_w),
  .tick  (tick_w),
  .ack   (ack_w),
  .cmd   (cmd_w)
);

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, scl = 1'b1, sda = 1'b1;
  logic sda_o;
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom_slave u_serial_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .scl_i(scl), .sda_i(sda), .sda_o(sda_o)
  );

  function automatic logic [7:0] img(int unsigned a);
    return 8'((a * 5 + 'h3C) & 'hFF);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(logic c, logic d);
    @(negedge clk);
    scl = c; sda = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic bit_out(logic b);
    drv(1'b0, b);
    drv(1'b1, b);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) bit_out(v[i]);
  endtask

  task automatic start_c();
    drv(1'b1, 1'b1);
    drv(1'b1, 1'b0);
  endtask

  task automatic stop_c();
    drv(1'b0, 1'b0);
    drv(1'b1, 1'b0);
    drv(1'b1, 1'b1);
  endtask

  task automatic ack_clk(string req, logic exp);
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b1);
    check(req, {7'b0, sda_o}, {7'b0, exp});
  endtask

  // address phase: returns sda_o seen after each rising edge
  task automatic addr_phase(logic [7:0] a, output logic [7:0] obs);
    for (int i = 7; i >= 0; i--) begin
      bit_out(a[i]);
      obs[i] = sda_o;
    end
  endtask

  task automatic txn(logic [7:0] c, logic [7:0] a, output logic [7:0] obs);
    start_c();
    send_bits(c, 8);
    ack_clk("R5 command ack", 1'b0);
    addr_phase(a, obs);
    ack_clk("R8 address ack", 1'b0);
    stop_c();
  endtask

  task automatic t_reset();
    check("R1 reset line released", {7'b0, sda_o}, 8'h01);
  endtask

  task automatic t_idle();
    send_bits(8'hA0, 8);
    ack_clk("R3 no ack without start", 1'b1);
    bit_out(1'b0);
    check("R3 idle bit not driven", {7'b0, sda_o}, 8'h00);
    bit_out(1'b1);
    check("R3 idle bit follows master", {7'b0, sda_o}, 8'h01);
  endtask

  task automatic t_write_point(logic [7:0] a);
    logic [7:0] obs;
    txn(8'hA0, a, obs);
    check("R7 write addr phase follows master", obs, a);
  endtask

  task automatic t_read(logic [7:0] a, logic [7:0] exp, string req);
    logic [7:0] obs;
    txn(8'hA1, a, obs);
    check(req, obs, exp);
  endtask

  task automatic t_bad_bit();
    logic [7:0] obs;
    start_c();
    send_bits(8'hA0, 7);
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b0);   // SDA differs at the rising edge: no bit
    bit_out(1'b0);
    ack_clk("R4 changed-SDA edge ignored", 1'b0);
    addr_phase(8'h10, obs);
    ack_clk("R8 ack after bad-bit txn", 1'b0);
    stop_c();
  endtask

  task automatic t_mid_stop();
    logic [7:0] obs;
    start_c();
    send_bits(8'hA0, 4);      // line ends at 0 with SCL high
    drv(1'b1, 1'b1);          // stop inside the byte
    send_bits(8'h00, 4);
    ack_clk("R2 stop keeps bit count", 1'b0);
    addr_phase(8'h10, obs);
    ack_clk("R8 ack after mid stop", 1'b0);
    stop_c();
  endtask

  task automatic t_restart_and_hold();
    logic [7:0] obs;
    start_c();
    send_bits(8'hA1, 3);
    start_c();                // repeated start restarts the count
    send_bits(8'hA0, 8);
    ack_clk("R2 repeated start restarts command", 1'b0);
    @(negedge clk); sda = 1'b1; scl = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 no strobe keeps ack low", {7'b0, sda_o}, 8'h00);
    scl = 1'b1;
    addr_phase(8'h2A, obs);
    check("R7 addr after restart follows master", obs, 8'h2A);
    ack_clk("R8 ack after restart", 1'b0);
    stop_c();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_idle();
    t_write_point(8'h10);
    t_read(8'hFF, img(8'h10), "R6 R9 read returns byte at 0x10");
    t_read(8'hFF, img(8'hFF), "R9 read returns byte at 0xFF");
    t_read(8'h0F, img(8'hFF) & 8'h0F, "R6 R11 wired-AND with master");
    t_read(8'hFF, img(8'h0F), "R8 load uses full address 0x0F");
    t_bad_bit();
    t_read(8'hFF, img(8'h10), "R4 bad-bit txn pointed at 0x10");
    t_mid_stop();
    t_restart_and_hold();
    t_read(8'hFF, img(8'h2A), "R9 read returns byte at 0x2A");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule